// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block holds a small table of 8-byte segment descriptors and judges one memory access per cycle against the entry a selector points at. A requester presents a selector, its current privilege level, the kind of access (read, write or execute) and a byte offset together with a request strobe. One clock later the block answers with either a grant or a fault, plus a 3-bit code that names the first rule that was broken.

The checks cover five areas:
- selector 0 is treated as the null descriptor;
- the present bit must be set;
- the type bits are read differently for code segments and data segments;
- the privilege level is compared, including the conforming-code rule for execution;
- the offset is compared with the segment limit, which may count bytes or 4 KB pages.

Software fills the table through a one-entry-per-cycle write port. The base address and the remaining attribute bits are stored but not used by any check.

Top module: `seg_access_check`

## Requirements
- R1: A request sampled at a rising edge produces `rsp_valid_o`=1 after that edge, with exactly one of `grant_o`/`fault_o` set. `cause_o`=0 on a grant. A cycle without a request leaves `rsp_valid_o`, `grant_o` and `fault_o` at 0 after the next edge.
- R2: Reset clears every table entry to zero. A write on `wr_en_i` is seen by requests in later cycles. A request in the same cycle as a write to its entry sees the previous content.
- R3: Selector 0 always faults with cause 1, whatever entry 0 holds.
- R4: A descriptor whose present bit (bit 47) is 0 faults with cause 2.
- R5: Type rules for data segments (bit 43 = 0) and for all segments: access code 0 is read, 1 is write, 2 is execute, 3 is reserved. For a data segment, read is allowed, write needs bit 41 set, and execute faults. A descriptor with bit 44 = 0 faults any access. Access code 3 always faults. Every type fault carries cause 3.
- R6: Type rules for code segments (bit 43 = 1): a write always faults with cause 3, a read needs bit 41 set, and execute is allowed.
- R7: For data accesses and for reads of code, the privilege level must be numerically at most the descriptor level (bits 46:45), else the access faults with cause 4.
- R8: For execution with bit 42 (conforming) set, the privilege level must be numerically at least the descriptor level. With bit 42 clear, it must be equal. A violation faults with cause 4.
- R9: The limit is {bits 51:48, bits 15:0}. With bit 55 = 0 it counts bytes, and an offset above it faults with cause 5.
- R10: With bit 55 = 1 the effective limit is limit×4096 + 4095. An offset above it faults with cause 5.
- R11: When several rules fail, the reported cause is the first in the order null (1), not present (2), type (3), privilege (4), limit (5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | IDX_W | Entry to write |
| wr_desc_i | input | 64 | Descriptor to store |
| req_i | input | 1 | Access request strobe |
| sel_i | input | IDX_W | Selector index of the access |
| cpl_i | input | 2 | Current privilege level |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| ofs_i | input | 32 | Byte offset within the segment |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| grant_o | output | 1 | Access allowed |
| fault_o | output | 1 | Access refused |
| cause_o | output | 3 | 0 none, 1 null, 2 absent, 3 type, 4 privilege, 5 limit |

## Verification
The response to a request is due exactly one rising edge after the request is sampled, and a table write affects only requests from the next edge on. The bench drives inputs just after a falling edge. At each rising edge its behavioural model computes the expected response from its own copy of the table, taken before that edge's write is applied. At the following falling edge the outputs are compared with that expectation, so every check samples exactly one edge after its stimulus, with no race at the edge. The sweep crosses all selectors, privilege levels, access codes and offsets placed on both sides of each limit.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int DESC_W = 64;
    localparam int OFS_W  = 32;
    localparam int LIM_W  = 20;
    localparam int PAGE_SH = 12;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_NULL   = 3'd1,
        CAUSE_ABSENT = 3'd2,
        CAUSE_TYPE   = 3'd3,
        CAUSE_PRIV   = 3'd4,
        CAUSE_LIMIT  = 3'd5
    } cause_e;

    typedef struct packed {
        logic       present;
        logic [1:0] dpl;
        logic       nonsys;
        logic       is_code;
        logic       conf_dir;
        logic       rw;
        logic       page_gran;
        logic [LIM_W-1:0] limit;
    } desc_view_t;

    typedef struct packed {
        logic   valid;
        logic   grant;
        logic   fault;
        cause_e cause;
    } rsp_t;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_chk_pkg::*;
#(
    parameter int NUM_DESC = 8,
    localparam int IDX_W = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DESC_W-1:0] wr_desc_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DESC_W-1:0] rd_desc_o
);

    logic [DESC_W-1:0] slot_all [NUM_DESC];

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
        logic [DESC_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                slot_d = wr_desc_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign slot_all[g] = slot_q;
    end

    assign rd_desc_o = slot_all[rd_idx_i];

endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
    import seg_chk_pkg::*;
(
    input  logic [DESC_W-1:0] desc_i,
    input  logic              sel_null_i,
    input  logic [1:0]        cpl_i,
    input  acc_e              acc_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output cause_e            cause_o
);

    desc_view_t v;
    logic [OFS_W-1:0] eff_lim;
    logic type_bad, priv_bad, lim_bad;
    logic unused_desc_bits;

    assign unused_desc_bits = ^{desc_i[63:56], desc_i[54:52], desc_i[40:16]};

    always_comb begin
        v.present   = desc_i[47];
        v.dpl       = desc_i[46:45];
        v.nonsys    = desc_i[44];
        v.is_code   = desc_i[43];
        v.conf_dir  = desc_i[42];
        v.rw        = desc_i[41];
        v.page_gran = desc_i[55];
        v.limit     = {desc_i[51:48], desc_i[15:0]};
    end

    always_comb begin
        if (v.page_gran) begin
            eff_lim = {v.limit, {PAGE_SH{1'b1}}};
        end else begin
            eff_lim = OFS_W'(v.limit);
        end
    end

    always_comb begin
        type_bad = 1'b0;
        if (!v.nonsys || acc_i == ACC_RSVD) begin
            type_bad = 1'b1;
        end else if (v.is_code) begin
            type_bad = (acc_i == ACC_WRITE) || (acc_i == ACC_READ && !v.rw);
        end else begin
            type_bad = (acc_i == ACC_EXEC) || (acc_i == ACC_WRITE && !v.rw);
        end
    end

    always_comb begin
        if (v.is_code && acc_i == ACC_EXEC) begin
            priv_bad = v.conf_dir ? (cpl_i < v.dpl) : (cpl_i != v.dpl);
        end else begin
            priv_bad = (cpl_i > v.dpl);
        end
    end

    assign lim_bad = (ofs_i > eff_lim);

    always_comb begin
        if (sel_null_i)       cause_o = CAUSE_NULL;
        else if (!v.present)  cause_o = CAUSE_ABSENT;
        else if (type_bad)    cause_o = CAUSE_TYPE;
        else if (priv_bad)    cause_o = CAUSE_PRIV;
        else if (lim_bad)     cause_o = CAUSE_LIMIT;
        else                  cause_o = CAUSE_NONE;
    end

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
    import seg_chk_pkg::*;
#(
    parameter int NUM_DESC = 8,
    localparam int IDX_W = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [63:0]       wr_desc_i,
    input  logic              req_i,
    input  logic [IDX_W-1:0]  sel_i,
    input  logic [1:0]        cpl_i,
    input  logic [1:0]        acc_i,
    input  logic [31:0]       ofs_i,
    output logic              rsp_valid_o,
    output logic              grant_o,
    output logic              fault_o,
    output logic [2:0]        cause_o
);

    logic [DESC_W-1:0] cur_desc;
    cause_e            chk_cause;
    rsp_t              rsp_d, rsp_q;

    seg_desc_table #(.NUM_DESC(NUM_DESC)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_desc_i (wr_desc_i),
        .rd_idx_i  (sel_i),
        .rd_desc_o (cur_desc)
    );

    seg_rule_eval u_eval (
        .desc_i     (cur_desc),
        .sel_null_i (sel_i == '0),
        .cpl_i      (cpl_i),
        .acc_i      (acc_e'(acc_i)),
        .ofs_i      (ofs_i),
        .cause_o    (chk_cause)
    );

    always_comb begin
        rsp_d = '0;
        if (req_i) begin
            rsp_d.valid = 1'b1;
            rsp_d.cause = chk_cause;
            if (chk_cause == CAUSE_NONE) rsp_d.grant = 1'b1;
            else                         rsp_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign grant_o     = rsp_q.grant;
    assign fault_o     = rsp_q.fault;
    assign cause_o     = rsp_q.cause;

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rsp_valid_o && (grant_o != fault_o)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !rsp_valid_o && !grant_o && !fault_o); // R1
    AST_NULL_SEL_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sel_i == '0) |=> fault_o && cause_o == 3'd1); // R3
    AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sel_i != '0 && !cur_desc[47]) |=> fault_o && cause_o == 3'd2); // R4
    AST_CODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && sel_i != '0 && cur_desc[47] && cur_desc[43] && acc_i == 2'd1)
        |=> fault_o && cause_o == 3'd3); // R6

endmodule

// File: tb/seg_access_check_bench.sv
module seg_access_check_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NDESC = 8;
    localparam int IW = $clog2(NDESC);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [IW-1:0] wr_idx_i = '0;
    logic [63:0]   wr_desc_i = '0;
    logic          req_i = 1'b0;
    logic [IW-1:0] sel_i = '0;
    logic [1:0]    cpl_i = '0;
    logic [1:0]    acc_i = '0;
    logic [31:0]   ofs_i = '0;
    logic          rsp_valid_o, grant_o, fault_o;
    logic [2:0]    cause_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string ctx_tag = "";

    logic [63:0] mtab [NDESC];
    logic        exp_valid = 0, exp_grant = 0, exp_fault = 0;
    int          exp_cause = 0;
    string       exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_access_check #(.NUM_DESC(NDESC)) u_seg_access_check (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .wr_desc_i(wr_desc_i), .req_i(req_i), .sel_i(sel_i), .cpl_i(cpl_i),
        .acc_i(acc_i), .ofs_i(ofs_i), .rsp_valid_o(rsp_valid_o),
        .grant_o(grant_o), .fault_o(fault_o), .cause_o(cause_o)
    );

    function automatic logic [63:0] mkd(logic [31:0] base, logic [19:0] lim,
                                        logic [7:0] acc, logic [3:0] flg);
        return {base[31:24], flg, lim[19:16], acc, base[23:0], lim[15:0]};
    endfunction

    function automatic int ref_cause(logic [63:0] d, int sel, int cpl, int acc,
                                     longint ofs, output string tag);
        int dpl = int'(d[46:45]);
        bit code = d[43];
        longint lim = longint'({d[51:48], d[15:0]});
        if (d[55]) lim = lim * 4096 + 4095;
        if (sel == 0) begin tag = "R3"; return 1; end
        if (!d[47]) begin tag = "R4"; return 2; end
        tag = code ? "R6" : "R5";
        if (!d[44] || acc == 3) return 3;
        if (code && (acc == 1 || (acc == 0 && !d[41]))) return 3;
        if (!code && (acc == 2 || (acc == 1 && !d[41]))) return 3;
        if (code && acc == 2) begin
            tag = "R8";
            if (d[42] && cpl < dpl) return 4;
            if (!d[42] && cpl != dpl) return 4;
        end else begin
            tag = "R7";
            if (cpl > dpl) return 4;
        end
        tag = d[55] ? "R10" : "R9";
        if (ofs > lim) return 5;
        tag = "R1";
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NDESC; i++) mtab[i] <= '0;
            exp_valid <= 0; exp_grant <= 0; exp_fault <= 0; exp_cause <= 0;
            exp_tag <= "R1";
        end else begin
            if (req_i) begin
                string t;
                int c;
                c = ref_cause(mtab[sel_i], int'(sel_i), int'(cpl_i), int'(acc_i),
                              longint'(ofs_i), t);
                exp_valid <= 1; exp_grant <= (c == 0); exp_fault <= (c != 0);
                exp_cause <= c;
                exp_tag <= (ctx_tag != "") ? ctx_tag : t;
            end else begin
                exp_valid <= 0; exp_grant <= 0; exp_fault <= 0; exp_cause <= 0;
                exp_tag <= "R1";
            end
            if (wr_en_i) mtab[wr_idx_i] <= wr_desc_i;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rsp_valid_o !== exp_valid || grant_o !== exp_grant ||
                fault_o !== exp_fault || int'(cause_o) != exp_cause) begin
                failures++;
                $display("FAIL %s: actual v=%0b g=%0b f=%0b cause=%0d expected v=%0b g=%0b f=%0b cause=%0d",
                         exp_tag, rsp_valid_o, grant_o, fault_o, cause_o,
                         exp_valid, exp_grant, exp_fault, exp_cause);
            end
        end
    end

    task automatic cyc(bit we, int widx, logic [63:0] wd, bit rq, int sel,
                       int cpl, int acc, logic [31:0] ofs);
        wr_en_i = we; wr_idx_i = IW'(widx); wr_desc_i = wd;
        req_i = rq; sel_i = IW'(sel); cpl_i = 2'(cpl); acc_i = 2'(acc); ofs_i = ofs;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual run still going expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] offs [8];
        offs = '{32'h0, 32'hFFF, 32'h1000, 32'hFFFF, 32'h10000, 32'h10FFF,
                 32'h11000, 32'hFFFF_FFFF};
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid_o !== 0 || grant_o !== 0 || fault_o !== 0 || cause_o !== 0) begin
            failures++;
            $display("FAIL R1: actual reset outputs v=%0b g=%0b f=%0b c=%0d expected all 0",
                     rsp_valid_o, grant_o, fault_o, cause_o);
        end
        rst_n = 1'b1;
        // R2: table cleared by reset, entry 3 reads as absent
        ctx_tag = "R2";
        cyc(0, 0, '0, 1, 3, 0, 0, 0);
        ctx_tag = "";
        cyc(1, 1, mkd(32'h1000, 20'h0FFFF, 8'hF2, 4'h0), 0, 0, 0, 0, 0);
        cyc(1, 2, mkd(32'h2000, 20'h00010, 8'h90, 4'h8), 0, 0, 0, 0, 0);
        cyc(1, 3, mkd(32'h0,    20'hFFFFF, 8'h9A, 4'h8), 0, 0, 0, 0, 0);
        cyc(1, 4, mkd(32'h4000, 20'h0FFFF, 8'hBC, 4'h4), 0, 0, 0, 0, 0);
        cyc(1, 5, mkd(32'h5000, 20'h0FFFF, 8'h72, 4'h0), 0, 0, 0, 0, 0);
        cyc(1, 6, mkd(32'h6000, 20'h0FFFF, 8'h89, 4'h0), 0, 0, 0, 0, 0);
        cyc(1, 7, mkd(32'h7000, 20'h00000, 8'hD2, 4'h8), 0, 0, 0, 0, 0);
        cyc(1, 0, mkd(32'h0,    20'hFFFFF, 8'hF2, 4'h8), 0, 0, 0, 0, 0);
        for (int s = 0; s < NDESC; s++)
            for (int c = 0; c < 4; c++)
                for (int a = 0; a < 4; a++)
                    for (int o = 0; o < 8; o++)
                        cyc(0, 0, '0, 1, s, c, a, offs[o]);
        cyc(0, 0, '0, 0, 0, 0, 0, 0);
        // R11: several rules broken at once
        ctx_tag = "R11";
        cyc(0, 0, '0, 1, 5, 3, 2, 32'hFFFF_FFFF);
        cyc(0, 0, '0, 1, 4, 0, 1, 32'hFFFF_FFFF);
        cyc(0, 0, '0, 1, 2, 3, 1, 32'h0002_0000);
        cyc(0, 0, '0, 1, 2, 3, 0, 32'h0002_0000);
        cyc(0, 0, '0, 1, 0, 3, 3, 32'hFFFF_FFFF);
        // R2: write and request to the same entry in one cycle
        ctx_tag = "R2";
        cyc(1, 7, mkd(32'h0, 20'h00000, 8'h52, 4'h0), 1, 7, 0, 0, 32'h10);
        cyc(0, 0, '0, 1, 7, 0, 0, 32'h10);
        cyc(0, 0, '0, 0, 0, 0, 0, 0);
        ctx_tag = "";
        cyc(0, 0, '0, 0, 0, 0, 0, 0);
        finish_run();
    end

endmodule